// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block is the digital sequencing core of a buck controller that can run with two, three or four phases. When it is enabled, it first opens a short detection window. During the window, phases 3 and 4 are placed in a weak detect drive, and two comparator flags report whether either of those outputs is held to ground. On the master-clock tick that closes the window, the block reads the two flags and fixes the number of active phases. It then hands each following master tick to the next active phase in turn. A phase turns on at its tick and stays on until its own off request arrives. As a result, phases may overlap and a duty cycle close to 100% is possible.

All pins are plain level or single-cycle control signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. A master tick is a one-cycle pulse on `tick`. An off request is a one-cycle (or longer) level on the matching `off_req` bit. Bit i of `pwm` and `off_req` belongs to phase i+1.

Top module: `mpwm_sequencer`

## Requirements
- R1: One cycle after `en` is sampled high from the disabled state, `det_drive` goes high. It stays high until the second `tick` after that point has been sampled. During this window all four `pwm` bits are low.
- R2: The flags are read on the second tick of the window. Both flags low selects 4 phases. `p4_low`=1 with `p3_low`=0 selects 3 phases. Both flags high selects 2 phases.
- R3: `p3_low`=1 with `p4_low`=0 also selects 2 phases, so phases 3 and 4 are both disabled.
- R4: Only the flag values on the closing tick of the window count. Flag changes before that tick, and any changes after it, have no effect until `en` is deasserted.
- R5: After the window, each sampled `tick` sets exactly one `pwm` bit on the next cycle. The order is phase 1, 2, 3, 4, wrapping after the last active phase. The first tick after the window goes to phase 1. No `pwm` bit rises without a tick.
- R6: A phase that detection has disabled never drives its `pwm` bit high while the block stays enabled.
- R7: `off_req[i]` clears `pwm[i]` on the next cycle and leaves all other bits unchanged. Several `pwm` bits may be high at once.
- R8: If a phase's turn-on tick and its off request are sampled in the same cycle, the phase ends up on.
- R9: When `en` is sampled low, all `pwm` bits and `det_drive` are low on the next cycle. The next enable starts a new detection window.
- R10: While `rst_n` is low, `pwm` is 0 and `det_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low clears the block and rearms detection |
| tick | input | 1 | One-cycle master-clock tick |
| p3_low | input | 1 | Comparator flag: phase 3 output held low |
| p4_low | input | 1 | Comparator flag: phase 4 output held low |
| off_req | input | 4 | Per-phase termination requests |
| pwm | output | 4 | Per-phase PWM logic levels |
| det_drive | output | 1 | Weak detect drive enable for phases 3 and 4 |

## Verification
The hardest case to reach is a turn-on tick and an off request landing on the same phase in the same cycle. To get there, the stimulus must track the rotation pointer through the ports alone. The bench does this by running a full rotation in 4-phase mode without any off requests, which leaves every phase high. It then clears all phases, so the next tick is known to target phase 1, and fires that tick together with off requests on every phase. The flag-latching rule is driven in a similar way. The bench raises a flag only between the two window ticks, and later swaps the flags in the middle of a run, then checks the length of the rotation.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_DETECT = 2'd1,
    SEQ_RUN    = 2'd2
  } seq_state_t;

  // Active phase count from the two ground flags; phase 3 low implies 2.
  function automatic int unsigned active_phases(input int unsigned nph,
                                                input logic p3_gnd,
                                                input logic p4_gnd);
    if (p3_gnd)      return nph - 2;
    else if (p4_gnd) return nph - 1;
    else             return nph;
  endfunction

endpackage

// File: rtl/mpwm_detect.sv
module mpwm_detect
  import mpwm_pkg::*;
#(
  parameter int NPH       = 4,
  parameter int DET_TICKS = 2,
  localparam int CW       = $clog2(NPH + 1),
  localparam int TW       = $clog2(DET_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          p3_gnd,
  input  logic          p4_gnd,
  output logic          run,
  output logic          det_drive,
  output logic [CW-1:0] act_cnt
);

  seq_state_t    state_q;
  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tcnt_q  <= '0;
      act_cnt <= CW'(NPH);
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          tcnt_q <= '0;
          if (en) state_q <= SEQ_DETECT;
        end
        SEQ_DETECT: begin
          if (!en) begin
            state_q <= SEQ_IDLE;
          end else if (tick) begin
            if (tcnt_q == TW'(DET_TICKS - 1)) begin
              act_cnt <= CW'(active_phases(NPH, p3_gnd, p4_gnd));
              state_q <= SEQ_RUN;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        SEQ_RUN: if (!en) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign run       = (state_q == SEQ_RUN);
  assign det_drive = (state_q == SEQ_DETECT);

endmodule

// File: rtl/mpwm_rotor.sv
module mpwm_rotor #(
  parameter int NPH  = 4,
  localparam int CW  = $clog2(NPH + 1),
  localparam int PW  = $clog2(NPH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           tick,
  input  logic [CW-1:0]  act_cnt,
  output logic [NPH-1:0] fire
);

  logic [PW-1:0] ptr_q;
  logic          last;

  assign last = ({1'b0, ptr_q} == (act_cnt - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr_q <= '0;
    else if (!go)        ptr_q <= '0;
    else if (tick)       ptr_q <= last ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    fire = '0;
    if (go && tick) fire[ptr_q] = 1'b1;
  end

endmodule

// File: rtl/mpwm_phase_cell.sv
module mpwm_phase_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic fire,
  input  logic off,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (!live) q <= 1'b0;
    else if (fire)  q <= 1'b1;
    else if (off)   q <= 1'b0;
  end

endmodule

// File: rtl/mpwm_sequencer.sv
module mpwm_sequencer #(
  parameter int NPH       = 4,
  parameter int DET_TICKS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic           p3_low,
  input  logic           p4_low,
  input  logic [NPH-1:0] off_req,
  output logic [NPH-1:0] pwm,
  output logic           det_drive
);

  localparam int CW = $clog2(NPH + 1);

  logic          run;
  logic          live;
  logic [CW-1:0] act_cnt;
  logic [NPH-1:0] fire;

  mpwm_detect #(.NPH(NPH), .DET_TICKS(DET_TICKS)) u_detect (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .p3_gnd(p3_low), .p4_gnd(p4_low),
    .run(run), .det_drive(det_drive), .act_cnt(act_cnt)
  );

  assign live = en && run;

  mpwm_rotor #(.NPH(NPH)) u_rotor (
    .clk(clk), .rst_n(rst_n), .go(live), .tick(tick),
    .act_cnt(act_cnt), .fire(fire)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    mpwm_phase_cell u_cell (
      .clk(clk), .rst_n(rst_n), .live(live),
      .fire(fire[i]), .off(off_req[i]), .q(pwm[i])
    );
  end

endmodule

// File: rtl/mpwm_seq_checker.sv
module mpwm_seq_checker #(
  parameter int NPH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           tick,
  input logic [NPH-1:0] off_req,
  input logic [NPH-1:0] pwm,
  input logic           det_drive
);

  assert_window_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    det_drive |-> (pwm == '0));

  assert_single_turnon_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwm & ~$past(pwm)) <= 1);

  assert_rise_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pwm & ~$past(pwm))) |-> $past(tick));

  assert_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> ((pwm & $past(off_req)) == '0));

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((pwm == '0) && !det_drive));

  always_comb begin
    if (!rst_n) assert_reset_state_R10: assert (pwm == '0 && !det_drive);
  end

endmodule

bind mpwm_sequencer mpwm_seq_checker #(.NPH(NPH)) u_seq_checker (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
  .off_req(off_req), .pwm(pwm), .det_drive(det_drive)
);

// File: tb/test_mpwm_sequencer.sv
module test_mpwm_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tick = 1'b0;
  logic       p3_low = 1'b0;
  logic       p4_low = 1'b0;
  logic [3:0] off_req = '0;
  logic [3:0] pwm;
  logic       det_drive;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mpwm_sequencer i_mpwm_sequencer (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .p3_low(p3_low), .p4_low(p4_low), .off_req(off_req),
    .pwm(pwm), .det_drive(det_drive)
  );

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_tick(input logic [3:0] offs);
    tick = 1'b1; off_req = offs;
    @(negedge clk);
    tick = 1'b0; off_req = '0;
  endtask

  task automatic pulse_off(input logic [3:0] offs);
    off_req = offs;
    @(negedge clk);
    off_req = '0;
  endtask

  // Enable and run the detection window; outputs {det_drive, pwm}.
  task automatic open_window(input logic f3, input logic f4);
    en = 1'b0; idle(2);
    p3_low = f3; p4_low = f4; en = 1'b1;
    @(negedge clk);
    chk("R1 window open", {det_drive, pwm}, 5'b1_0000);
    pulse_tick('0);
    chk("R1 window mid", {det_drive, pwm}, 5'b1_0000);
    pulse_tick('0);
    chk("R1 window closed", {det_drive, pwm}, 5'b0_0000);
  endtask

  task automatic rotate(input string tag, input int n, input int turns);
    for (int k = 0; k < turns; k++) begin
      pulse_tick('0);
      chk(tag, {det_drive, pwm}, {1'b0, 4'(1 << (k % n))});
      pulse_off(4'hF);
      chk("R7 cleared", {det_drive, pwm}, 5'b0);
    end
  endtask

  task automatic t_reset;
    chk("R10 reset", {det_drive, pwm}, 5'b0);
    @(negedge clk); rst_n = 1'b1; idle(1);
    chk("R10 after reset", {det_drive, pwm}, 5'b0);
  endtask

  task automatic t_counts;
    open_window(1'b0, 1'b0); rotate("R2 4-phase rotation R5", 4, 8);
    open_window(1'b0, 1'b1); rotate("R2 3-phase rotation R6", 3, 6);
    open_window(1'b1, 1'b1); rotate("R2 2-phase rotation R6", 2, 4);
    open_window(1'b1, 1'b0); rotate("R3 phase3-only low gives 2", 2, 4);
  endtask

  task automatic t_latch;
    en = 1'b0; idle(2);
    p3_low = 1'b1; p4_low = 1'b0; en = 1'b1;
    idle(1);
    pulse_tick('0);
    p3_low = 1'b0; p4_low = 1'b1;          // only closing-tick values count
    pulse_tick('0);
    rotate("R4 flags at closing tick", 3, 3);
    p3_low = 1'b1; p4_low = 1'b0;          // ignored while enabled
    rotate("R4 later flags ignored", 3, 6);
    p3_low = 1'b0; p4_low = 1'b0;
  endtask

  task automatic t_overlap;
    open_window(1'b0, 1'b0);
    pulse_tick('0); pulse_tick('0); pulse_tick('0);
    chk("R7 overlap", {det_drive, pwm}, 5'b0_0111);
    pulse_tick('0);
    chk("R7 all high", {det_drive, pwm}, 5'b0_1111);
    pulse_off(4'b0010);
    chk("R7 independent off", {det_drive, pwm}, 5'b0_1101);
    pulse_off(4'hF);
    pulse_tick(4'hF);                      // tick targets phase 1 with its off
    chk("R8 turn-on wins", {det_drive, pwm}, 5'b0_0001);
    pulse_tick('0);
    chk("R8 then phase 2", {det_drive, pwm}, 5'b0_0011);
  endtask

  task automatic t_disable;
    en = 1'b0;
    @(negedge clk);
    chk("R9 disable clears", {det_drive, pwm}, 5'b0);
    pulse_tick('0);
    chk("R9 ticks ignored", {det_drive, pwm}, 5'b0);
    en = 1'b1;
    @(negedge clk);
    chk("R9 detect restarts", {det_drive, pwm}, 5'b1_0000);
    en = 1'b0; idle(1);
  endtask

  initial begin
    idle(2);
    t_reset();
    t_counts();
    t_latch();
    t_overlap();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule